// File: doc/BRIEF.md
# Resonant Half-Bridge Ramp Oscillator

This block is the timing core of a resonant half-bridge controller in digital form. A ramp counter climbs from a lower threshold to an upper threshold at a programmable rate and then drops back at a fixed rate. Each climb turns on one of the two bridge gates, the low-side gate and the high-side gate in turn. During each drop both gates are off. The length of the drop is the dead time, and the climb rate sets the switching frequency: a larger charge step gives a shorter period. The two thresholds are at counter values 3K and 5K, in the ratio three to five.

When the block is enabled, the first pulse is always on the low-side gate. That pulse starts with the ramp at zero and lasts until the ramp first reaches the upper threshold, so the high-side supply can charge before any high-side pulse. A soft-start offset is added to the charge step. It makes the first cycles fast, and it halves after every few ramp tops until only the programmed step remains. The offset reloads whenever the block is off, and also on an explicit restart request. A force-off input from the supervisor blanks both gates at once and returns the ramp to zero.

The block has no data stream. Every pin is a plain control or status level sampled on the clock, so there is no valid/ready pairing and no back-pressure.

Top module: `hb_ramp_osc`

## Requirements
- R1: While reset is held, and in any cycle after a clock edge where `en` was low, `lo`, `ho` and `top_stb` are low and `ramp` is 0.
- R2: In the first cycle after an edge where `en` is high and `force_off` is low, coming from the off state, `lo` is high and `ramp` is 0. `lo` then stays high until the ramp reaches 5K, with no `ho` pulse before that.
- R3: `lo` and `ho` are never high together. Climbs after the first alternate high-side, low-side, high-side, and so on.
- R4: After each top, the ramp falls by FALL_STEP per cycle from 5K and stops at 3K. Both gates stay low for 2K/FALL_STEP cycles, which is 8 with the default parameters.
- R5: During a climb the ramp rises each cycle by `chg_step` plus the soft-start offset, with a sum of 0 treated as 1. It is clamped at 5K, and later climbs start from 3K.
- R6: `force_off` high drives `lo`, `ho` and `top_stb` low in the same cycle, and `ramp` is 0 in the cycle after the edge.
- R7: `top_stb` is high for exactly one cycle in the first cycle at the ramp top (when `ramp` equals 5K) and in the cycle in which `lo` rises. It is low at all other times.
- R8: The soft-start offset is SS_START after the block is off or after `ss_restart`. It shifts right by one bit after every SS_CYCLES ramp tops and never grows between reloads.
- R9: Once the soft-start offset has decayed, the low-side to low-side period is 2*(ceil(2K/chg_step) + 2K/FALL_STEP) cycles. A larger step gives a shorter period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks the oscillator |
| chg_step | input | STEP_W | Programmed ramp charge step per cycle |
| ss_restart | input | 1 | Reload the soft-start offset |
| force_off | input | 1 | Supervisor shutdown, immediate gate blanking |
| lo | output | 1 | Low-side gate drive |
| ho | output | 1 | High-side gate drive |
| top_stb | output | 1 | One-cycle strobe at ramp top and at low-side turn-on |
| ramp | output | RAMP_W | Current ramp counter value |

## Verification
Every registered result (`ramp`, the phase behind `lo` and `ho`, and `top_stb`) is due in the cycle that follows the clock edge that sampled the inputs. The only exception is the `force_off` blanking of the gates and strobe, which is combinational and due in the same cycle. The bench changes inputs just after a falling edge and compares all four outputs 1 ns later against a cycle model. That model is stepped once per edge, so a same-cycle blanking and a next-cycle ramp clear are each checked in the cycle they are due. Directed checks measure the dead-time length and the settled periods in whole cycles between observed `lo` rises.

// File: rtl/hb_osc_pkg.sv
package hb_osc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_FALL  = 2'd2,
    ST_RISE  = 2'd3
  } osc_state_e;
endpackage

// File: rtl/hb_ss_decay.sv
module hb_ss_decay #(
  parameter int STEP_W    = 8,
  parameter int SS_START  = 128,
  parameter int SS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              restart,
  input  logic              top_now,
  output logic [STEP_W-1:0] offset
);
  localparam int CNT_W = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SS_CYCLES - 1);
  localparam logic [STEP_W-1:0] OFF_INIT = STEP_W'(SS_START);

  logic [CNT_W-1:0] tops_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= OFF_INIT;
      tops_q <= '0;
    end else if (reload || restart) begin
      offset <= OFF_INIT;
      tops_q <= '0;
    end else if (top_now) begin
      if (tops_q == CNT_LAST) begin
        offset <= offset >> 1;
        tops_q <= '0;
      end else begin
        tops_q <= tops_q + 1'b1;
      end
    end
  end

  // R8: between reloads the offset only decays
  a_r8_offset_decays: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !restart) |=> (offset <= $past(offset)));
endmodule

// File: rtl/hb_ramp_core.sv
module hb_ramp_core
  import hb_osc_pkg::*;
#(
  parameter int RAMP_W    = 16,
  parameter int STEP_W    = 8,
  parameter int K         = 256,
  parameter int FALL_STEP = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W:0]   step_eff,
  output osc_state_e        state,
  output logic [RAMP_W-1:0] ramp,
  output logic              side_hi,
  output logic              top_now,
  output logic              stb_q
);
  localparam logic [RAMP_W-1:0] TOP_V  = RAMP_W'(5 * K);
  localparam logic [RAMP_W-1:0] BOT_V  = RAMP_W'(3 * K);
  localparam logic [RAMP_W:0]   FALL_V = (RAMP_W+1)'(FALL_STEP);
  localparam logic [RAMP_W:0]   TURN_V = (RAMP_W+1)'(3 * K + FALL_STEP);

  logic [RAMP_W:0] up_sum;
  logic [RAMP_W:0] dn_val;
  logic            climbing;

  assign climbing = (state == ST_START) || (state == ST_RISE);
  assign up_sum   = {1'b0, ramp} + (RAMP_W+1)'(step_eff);
  assign dn_val   = {1'b0, ramp} - FALL_V;
  assign top_now  = run && climbing && (up_sum >= {1'b0, TOP_V});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ramp    <= '0;
      side_hi <= 1'b0;
      stb_q   <= 1'b0;
    end else if (!run) begin
      state   <= ST_IDLE;
      ramp    <= '0;
      side_hi <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state <= ST_START;
          ramp  <= '0;
          stb_q <= 1'b1;
        end
        ST_START, ST_RISE: begin
          if (top_now) begin
            ramp    <= TOP_V;
            state   <= ST_FALL;
            side_hi <= (state == ST_START) ? 1'b1 : ~side_hi;
            stb_q   <= 1'b1;
          end else begin
            ramp  <= up_sum[RAMP_W-1:0];
            stb_q <= 1'b0;
          end
        end
        ST_FALL: begin
          if ({1'b0, ramp} <= TURN_V) begin
            ramp  <= BOT_V;
            state <= ST_RISE;
            stb_q <= ~side_hi;
          end else begin
            ramp  <= dn_val[RAMP_W-1:0];
            stb_q <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: ramp never exceeds the upper threshold
  a_r5_ramp_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ramp <= TOP_V);
  // R6: halt returns the ramp to zero
  a_r6_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ramp == '0 && state == ST_IDLE));
  // R2: leaving idle always opens a low-side charge phase from zero
  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && run) |=> (state == ST_START && ramp == '0));
  // R4: the fall phase only moves downward
  a_r4_fall_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_FALL && $past(state) == ST_FALL) |-> (ramp < $past(ramp)));
endmodule

// File: rtl/hb_gate_decode.sv
module hb_gate_decode
  import hb_osc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  osc_state_e state,
  input  logic       side_hi,
  input  logic       force_off,
  input  logic       stb_q,
  output logic       lo,
  output logic       ho,
  output logic       top_stb
);
  always_comb begin
    lo      = !force_off && ((state == ST_START) || (state == ST_RISE && !side_hi));
    ho      = !force_off && (state == ST_RISE) && side_hi;
    top_stb = !force_off && stb_q;
  end

  // R3: gates are exclusive
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo && ho));
  // R4: both gates off during the fall
  a_r4_dead_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FALL) |-> (!lo && !ho));
  // R6: supervisor shutdown blanks everything at once
  a_r6_force_blank: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (!lo && !ho && !top_stb));
endmodule

// File: rtl/hb_ramp_osc.sv
module hb_ramp_osc
  import hb_osc_pkg::*;
#(
  parameter int RAMP_W    = 16,
  parameter int STEP_W    = 8,
  parameter int K         = 256,
  parameter int FALL_STEP = 64,
  parameter int SS_START  = 128,
  parameter int SS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [STEP_W-1:0] chg_step,
  input  logic              ss_restart,
  input  logic              force_off,
  output logic              lo,
  output logic              ho,
  output logic              top_stb,
  output logic [RAMP_W-1:0] ramp
);
  logic              run;
  logic [STEP_W-1:0] ss_off;
  logic [STEP_W:0]   step_sum;
  logic [STEP_W:0]   step_eff;
  osc_state_e        state;
  logic              side_hi;
  logic              top_now;
  logic              stb_q;

  assign run      = en && !force_off;
  assign step_sum = {1'b0, chg_step} + {1'b0, ss_off};
  assign step_eff = (step_sum == '0) ? (STEP_W+1)'(1) : step_sum;

  hb_ss_decay #(
    .STEP_W(STEP_W), .SS_START(SS_START), .SS_CYCLES(SS_CYCLES)
  ) u_ss (
    .clk(clk), .rst_n(rst_n), .reload(!run), .restart(ss_restart),
    .top_now(top_now), .offset(ss_off)
  );

  hb_ramp_core #(
    .RAMP_W(RAMP_W), .STEP_W(STEP_W), .K(K), .FALL_STEP(FALL_STEP)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .step_eff(step_eff),
    .state(state), .ramp(ramp), .side_hi(side_hi),
    .top_now(top_now), .stb_q(stb_q)
  );

  hb_gate_decode u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .side_hi(side_hi),
    .force_off(force_off), .stb_q(stb_q),
    .lo(lo), .ho(ho), .top_stb(top_stb)
  );

  // R7: strobe lasts a single cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (top_stb && !force_off) |=> !top_stb);
endmodule

// File: tb/test_hb_ramp_osc.sv
module test_hb_ramp_osc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] chg_step = 8'd0;
  logic       ss_restart = 1'b0;
  logic       force_off = 1'b0;
  logic       lo, ho, top_stb;
  logic [15:0] ramp;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 start, 2 fall, 3 rise
  int m_st = 0, m_ramp = 0, m_off = 128, m_cnt = 0;
  bit m_side = 0, m_stb = 0;

  always #10 clk = ~clk;

  hb_ramp_osc i_hb_ramp_osc (
    .clk(clk), .rst_n(rst_n), .en(en), .chg_step(chg_step),
    .ss_restart(ss_restart), .force_off(force_off),
    .lo(lo), .ho(ho), .top_stb(top_stb), .ramp(ramp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic model_step();
    bit top;
    int eff;
    top = 0;
    if (!en || force_off) begin
      m_st = 0; m_ramp = 0; m_side = 0; m_stb = 0; m_off = 128; m_cnt = 0;
    end else begin
      eff = int'(chg_step) + m_off;
      if (eff == 0) eff = 1;
      case (m_st)
        0: begin m_st = 1; m_ramp = 0; m_stb = 1; end
        1, 3: begin
          if (m_ramp + eff >= 1280) begin
            m_side = (m_st == 1) ? 1'b1 : !m_side;
            m_ramp = 1280; m_st = 2; m_stb = 1; top = 1;
          end else begin
            m_ramp += eff; m_stb = 0;
          end
        end
        default: begin
          if (m_ramp <= 832) begin
            m_ramp = 768; m_st = 3; m_stb = !m_side;
          end else begin
            m_ramp -= 64; m_stb = 0;
          end
        end
      endcase
      if (ss_restart) begin
        m_off = 128; m_cnt = 0;
      end else if (top) begin
        if (m_cnt == 3) begin m_off = m_off >> 1; m_cnt = 0; end
        else m_cnt++;
      end
    end
  endtask

  // compare with the model, advance it, move to the next falling edge
  task automatic tick();
    bit e_lo, e_ho, e_stb;
    #1;
    e_lo  = !force_off && (m_st == 1 || (m_st == 3 && !m_side));
    e_ho  = !force_off && m_st == 3 && m_side;
    e_stb = !force_off && m_stb;
    chk(lo == e_lo, "R3 lo", int'(lo), int'(e_lo));
    chk(ho == e_ho, "R3 ho", int'(ho), int'(e_ho));
    chk(int'(ramp) == m_ramp, "R5 ramp", int'(ramp), m_ramp);
    chk(top_stb == e_stb, "R7 top_stb", int'(top_stb), int'(e_stb));
    model_step();
    @(negedge clk);
  endtask

  // cycles between two observed lo rises
  task automatic lo_period(output int p);
    bit prev;
    int n;
    prev = 1'b1; n = 0;
    while (n < 5000) begin
      #1; if (lo && !prev) break;
      prev = lo; #0; tick(); n++;
    end
    p = 0; prev = 1'b1;
    while (p < 5000) begin
      tick(); p++;
      #1; if (lo && !prev) break;
      prev = lo;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    int p, dead, prev_lo;
    bit seen_ho;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!lo && !ho && !top_stb && ramp == 16'd0, "R1 reset outputs", int'(ramp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick(); tick();
    chk(!lo && ramp == 16'd0, "R1 disabled idle", int'(lo), 0);

    // R2: first pulse is low-side from zero until top, no ho before
    en = 1'b1; chg_step = 8'd40;
    tick();
    #1;
    chk(lo && !ho && ramp == 16'd0 && top_stb, "R2 first lo", int'(lo), 1);
    seen_ho = 0;
    while (ramp != 16'd1280 && vectors < 100000) begin
      if (ho) seen_ho = 1;
      tick(); #1;
    end
    chk(!seen_ho, "R2 no ho before first top", int'(seen_ho), 0);
    chk(top_stb && !lo, "R7 strobe at first top", int'(top_stb), 1);

    // R4: dead time length
    dead = 0;
    while (!lo && !ho && dead < 100) begin tick(); dead++; #1; end
    chk(dead == 8, "R4 dead cycles", dead, 8);
    chk(ho && ramp == 16'd768, "R3 second pulse high-side from 3K", int'(ho), 1);

    // R8: early period shorter than settled period
    lo_period(p);
    prev_lo = p;
    repeat (40) lo_period(p);
    chk(prev_lo < p, "R8 soft-start faster early", prev_lo, p);
    // R9: settled periods for two steps
    chk(p == 2 * (ceil_div(512, 40) + 8), "R9 period step 40", p, 2 * (ceil_div(512, 40) + 8));
    chg_step = 8'd64;
    lo_period(p); lo_period(p);
    chk(p == 32, "R9 period step 64", p, 32);
    chg_step = 8'd16;
    lo_period(p); lo_period(p);
    chk(p == 80, "R9 period step 16", p, 80);
    // R5: zero step treated as one
    chg_step = 8'd0;
    repeat (600) tick();

    // R6: force-off blanks same cycle, ramp zero next
    chg_step = 8'd50;
    while (!lo && vectors < 100000) begin tick(); #1; end
    force_off = 1'b1;
    #1;
    chk(!lo && !ho && !top_stb, "R6 same-cycle blank", int'(lo), 0);
    tick();
    #1;
    chk(ramp == 16'd0, "R6 ramp cleared", int'(ramp), 0);
    force_off = 1'b0;
    tick();
    #1;
    chk(lo && ramp == 16'd0, "R2 restart low-side after force-off", int'(lo), 1);

    // R8: restart reloads offset (model compares)
    ss_restart = 1'b1; tick(); ss_restart = 1'b0;

    // random phase
    for (int blk = 0; blk < 30; blk++) begin
      chg_step = 8'($urandom_range(255, 0));
      for (int c = 0; c < 200; c++) begin
        en         = ($urandom_range(199, 0) != 0);
        force_off  = ($urandom_range(99, 0) == 0);
        ss_restart = ($urandom_range(99, 0) == 0);
        tick();
      end
    end
    en = 1'b0; force_off = 1'b0; ss_restart = 1'b0;
    tick();
    #1;
    chk(!lo && !ho && ramp == 16'd0, "R1 disable parks", int'(ramp), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule